// File: doc/BRIEF.md
# FIR Filter Coprocessor

This block is a finite impulse response filter engine that sits on a processor's register bus. Software programs a filter length, a base position for the sample history and a base position for the coefficient table. It then loads the coefficients one at a time through a coefficient port and streams 24-bit fractional samples into a small input queue. For each queued sample the engine stores it in a circular history, runs one multiply-accumulate per tap, newest sample first, into a 56-bit accumulator, then rounds and limits the sum into a 24-bit result register.

The result register loads only when the last tap has been accumulated. It is then flagged valid. While a result waits unread, the engine starts no new sample. Two request lines pace the traffic: one asks for input while the queue has room and the engine is on, and the other asks for the waiting result. These lines can serve as DMA triggers. An interrupt line combines them under two enable bits. Samples and coefficients are signed fractions with 23 fraction bits.

Register map on `bus_addr`: 0 sample in (write), 1 result (read), 2 coefficient in (write), 3 tap count, 4 history base, 5 coefficient base, 6 control/status. Control/status bits: 0 engine on (rw), 1 queue has room (ro), 2 result valid (ro), 3 sticky drop flag (write 1 clears), 4 input interrupt enable, 5 output interrupt enable. Other offsets read zero.

Top module: `fir_coproc`

## Requirements
- R1: After reset the control/status register reads 0x000002, the result register reads 0, and `in_req`, `out_req` and `irq` are low.
- R2: The input queue holds 4 samples. Status bit 1 is 1 while fewer than 4 are held. A sample write while 4 are held is discarded and sets status bit 3. Bit 3 stays set until a control write with bit 3 = 1.
- R3: A tap-count write stores 1 when the value is 0, stores 16 when the value is above 16, and otherwise stores the value. Offset 3 reads back the stored count.
- R4: Each coefficient write lands at coefficient position (coefficient base + k) mod 16. k counts the coefficient writes since the last coefficient-base write, starting at 0.
- R5: Each consumed sample goes into a circular history of T entries, where T is the tap count. The output is y(n) = sum over j=0..T-1 of c[j]·x(n−j), with c[j] the coefficient at (coefficient base + j) mod 16. History positions never written count as zero after reset.
- R6: Rounding adds 2^22 to the 56-bit sum of raw 48-bit products and then shifts it arithmetically right by 23, so an exact half rounds toward plus infinity.
- R7: A rounded value above 0x7FFFFF gives 0x7FFFFF. A rounded value below −2^23 gives 0x800000.
- R8: The result register changes only when all T taps of a sample are done. At that point status bit 2 sets. No further sample is consumed until a read of offset 1 clears bit 2.
- R9: While status bit 0 is 0 no sample leaves the queue. Clearing bit 0 does not abort a computation already running.
- R10: `in_req` = bit0 AND bit1, `out_req` = bit2, and `irq` = (bit4 AND `in_req`) OR (bit5 AND `out_req`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe, one cycle per read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, valid in the cycle `bus_rd` is high |
| in_req | output | 1 | Input request (DMA trigger) |
| out_req | output | 1 | Result-ready request (DMA trigger) |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that software leaves the tap count, both base registers and the coefficient table alone while a sample is being processed. It also assumes that each bus access lasts one cycle, with read and write never high together. The bench follows these rules. It writes every setting before turning the engine on, or after a reset, and it waits for the valid flag before it reads a result. Only then does it feed the next sample to a filter whose settings might change. Queue overflow is forced while the engine is off, so the number of samples held is known exactly when the drop happens.

// File: rtl/fir_cop_pkg.sv
package fir_cop_pkg;

    localparam int DW      = 24;
    localparam int PRODW   = 2 * DW;
    localparam int ACCW    = 56;
    localparam int RND_SH  = DW - 1;

    typedef enum logic [2:0] {
        REG_SAMPLE = 3'd0,
        REG_RESULT = 3'd1,
        REG_COEF   = 3'd2,
        REG_TAPS   = 3'd3,
        REG_DBASE  = 3'd4,
        REG_CBASE  = 3'd5,
        REG_CSR    = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    localparam int CSR_EN     = 0;
    localparam int CSR_ROOM   = 1;
    localparam int CSR_VALID  = 2;
    localparam int CSR_DROP   = 3;
    localparam int CSR_IN_IE  = 4;
    localparam int CSR_OUT_IE = 5;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_FIN  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic signed [DW-1:0] coef;
        logic signed [DW-1:0] samp;
    } mac_op_t;

    function automatic logic [DW-1:0] round_limit(input logic signed [ACCW-1:0] acc);
        logic signed [ACCW:0] biased;
        logic signed [ACCW:0] shifted;
        logic signed [ACCW:0] hi_lim;
        logic signed [ACCW:0] lo_lim;
        hi_lim  = (ACCW+1)'(2 ** (DW - 1) - 1);
        lo_lim  = -(ACCW+1)'(2 ** (DW - 1));
        biased  = {acc[ACCW-1], acc} + (ACCW+1)'(2 ** (RND_SH - 1));
        shifted = biased >>> RND_SH;
        if (shifted > hi_lim)
            return {1'b0, {(DW-1){1'b1}}};
        else if (shifted < lo_lim)
            return {1'b1, {(DW-1){1'b0}}};
        else
            return shifted[DW-1:0];
    endfunction

endpackage

// File: rtl/fir_in_fifo.sv
module fir_in_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [W-1:0]                  wdata,
    input  logic                          pop,
    output logic [W-1:0]                  rdata,
    output logic                          full,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign level   = cnt;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else begin
            if (do_push) begin
                store[wr_ptr] <= wdata;
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/fir_addr_gen.sv
module fir_addr_gen #(
    parameter int MEM_DEPTH = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [$clog2(MEM_DEPTH+1)-1:0]     taps,
    input  logic [$clog2(MEM_DEPTH)-1:0]       data_base,
    input  logic [$clog2(MEM_DEPTH)-1:0]       coef_base,
    input  logic                               restart,
    input  logic                               advance,
    input  logic                               step,
    output logic [$clog2(MEM_DEPTH)-1:0]       wr_addr,
    output logic [$clog2(MEM_DEPTH)-1:0]       rd_data_addr,
    output logic [$clog2(MEM_DEPTH)-1:0]       rd_coef_addr,
    output logic                               last_tap
);
    localparam int AW = $clog2(MEM_DEPTH);
    localparam int TW = $clog2(MEM_DEPTH + 1);

    logic [TW-1:0] head, newest, idx;
    logic [TW:0]   back_off;

    always_comb begin
        if (newest >= idx)
            back_off = {1'b0, newest} - {1'b0, idx};
        else
            back_off = {1'b0, newest} + {1'b0, taps} - {1'b0, idx};
    end

    assign wr_addr      = data_base + head[AW-1:0];
    assign rd_data_addr = data_base + back_off[AW-1:0];
    assign rd_coef_addr = coef_base + idx[AW-1:0];
    assign last_tap     = (idx == taps - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            head   <= '0;
            newest <= '0;
            idx    <= '0;
        end else if (advance) begin
            newest <= head;
            head   <= (head == taps - 1'b1) ? '0 : head + 1'b1;
            idx    <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/fir_mac.sv
module fir_mac
    import fir_cop_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   en,
    input  mac_op_t                op,
    output logic signed [ACCW-1:0] acc,
    output logic [DW-1:0]          limited
);
    logic signed [PRODW-1:0] prod;
    logic signed [ACCW-1:0]  prod_ext;

    assign prod     = op.coef * op.samp;
    assign prod_ext = {{(ACCW-PRODW){prod[PRODW-1]}}, prod};
    assign limited  = round_limit(acc);

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (en)
            acc <= acc + prod_ext;
    end
endmodule

// File: rtl/fir_coproc.sv
module fir_coproc
    import fir_cop_pkg::*;
#(
    parameter int MEM_DEPTH  = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [23:0]   bus_wdata,
    output logic [23:0]   bus_rdata,
    output logic          in_req,
    output logic          out_req,
    output logic          irq
);
    localparam int AW = $clog2(MEM_DEPTH);
    localparam int TW = $clog2(MEM_DEPTH + 1);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    reg_sel_e   sel;
    logic       wr_sample, wr_coef, wr_taps, wr_dbase, wr_cbase, wr_csr, rd_result;

    logic [TW-1:0] taps_q;
    logic [AW-1:0] dbase_q, cbase_q, coef_k;
    logic          en_q, drop_q, in_ie_q, out_ie_q, out_valid;
    logic [DW-1:0] result_q;

    logic [DW-1:0] dmem [MEM_DEPTH];
    logic [DW-1:0] cmem [MEM_DEPTH];

    eng_state_e    state;
    logic          start, eng_fin, step;

    logic [DW-1:0] fifo_rdata;
    logic          fifo_full, fifo_empty;
    logic [LW-1:0] fifo_level;

    logic [AW-1:0] wr_addr, rd_data_addr, rd_coef_addr;
    logic          last_tap;

    mac_op_t                op;
    logic signed [ACCW-1:0] acc;
    logic [DW-1:0]          limited;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_sample = bus_wr && (sel == REG_SAMPLE);
    assign wr_coef   = bus_wr && (sel == REG_COEF);
    assign wr_taps   = bus_wr && (sel == REG_TAPS);
    assign wr_dbase  = bus_wr && (sel == REG_DBASE);
    assign wr_cbase  = bus_wr && (sel == REG_CBASE);
    assign wr_csr    = bus_wr && (sel == REG_CSR);
    assign rd_result = bus_rd && (sel == REG_RESULT);

    assign start   = (state == ENG_IDLE) && en_q && !fifo_empty && !out_valid;
    assign step    = (state == ENG_RUN);
    assign eng_fin = (state == ENG_FIN);

    fir_in_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_sample),
        .wdata (bus_wdata),
        .pop   (start),
        .rdata (fifo_rdata),
        .full  (fifo_full),
        .empty (fifo_empty),
        .level (fifo_level)
    );

    fir_addr_gen #(.MEM_DEPTH(MEM_DEPTH)) u_agen (
        .clk          (clk),
        .rst          (rst),
        .taps         (taps_q),
        .data_base    (dbase_q),
        .coef_base    (cbase_q),
        .restart      (wr_taps),
        .advance      (start),
        .step         (step),
        .wr_addr      (wr_addr),
        .rd_data_addr (rd_data_addr),
        .rd_coef_addr (rd_coef_addr),
        .last_tap     (last_tap)
    );

    assign op.coef = cmem[rd_coef_addr];
    assign op.samp = dmem[rd_data_addr];

    fir_mac u_mac (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .en      (step),
        .op      (op),
        .acc     (acc),
        .limited (limited)
    );

    // engine sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
        end else begin
            unique case (state)
                ENG_IDLE: if (start) state <= ENG_RUN;
                ENG_RUN:  if (last_tap) state <= ENG_FIN;
                ENG_FIN:  state <= ENG_IDLE;
                default:  state <= ENG_IDLE;
            endcase
        end
    end

    // sample history and coefficient storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) begin
                dmem[i] <= '0;
                cmem[i] <= '0;
            end
            coef_k <= '0;
        end else begin
            if (start)
                dmem[wr_addr] <= fifo_rdata;
            if (wr_cbase)
                coef_k <= '0;
            else if (wr_coef) begin
                cmem[cbase_q + coef_k] <= bus_wdata;
                coef_k <= coef_k + 1'b1;
            end
        end
    end

    // configuration, status and result
    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q    <= TW'(1);
            dbase_q   <= '0;
            cbase_q   <= '0;
            en_q      <= 1'b0;
            drop_q    <= 1'b0;
            in_ie_q   <= 1'b0;
            out_ie_q  <= 1'b0;
            out_valid <= 1'b0;
            result_q  <= '0;
        end else begin
            if (wr_taps) begin
                if (bus_wdata == '0)
                    taps_q <= TW'(1);
                else if (bus_wdata > 24'(MEM_DEPTH))
                    taps_q <= TW'(MEM_DEPTH);
                else
                    taps_q <= bus_wdata[TW-1:0];
            end
            if (wr_dbase) dbase_q <= bus_wdata[AW-1:0];
            if (wr_cbase) cbase_q <= bus_wdata[AW-1:0];
            if (wr_csr) begin
                en_q     <= bus_wdata[CSR_EN];
                in_ie_q  <= bus_wdata[CSR_IN_IE];
                out_ie_q <= bus_wdata[CSR_OUT_IE];
            end
            if (wr_sample && fifo_full)
                drop_q <= 1'b1;
            else if (wr_csr && bus_wdata[CSR_DROP])
                drop_q <= 1'b0;
            if (eng_fin) begin
                result_q  <= limited;
                out_valid <= 1'b1;
            end else if (rd_result) begin
                out_valid <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_RESULT: bus_rdata = result_q;
            REG_TAPS:   bus_rdata = 24'(taps_q);
            REG_DBASE:  bus_rdata = 24'(dbase_q);
            REG_CBASE:  bus_rdata = 24'(cbase_q);
            REG_CSR: begin
                bus_rdata[CSR_EN]     = en_q;
                bus_rdata[CSR_ROOM]   = !fifo_full;
                bus_rdata[CSR_VALID]  = out_valid;
                bus_rdata[CSR_DROP]   = drop_q;
                bus_rdata[CSR_IN_IE]  = in_ie_q;
                bus_rdata[CSR_OUT_IE] = out_ie_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign in_req  = en_q && !fifo_full;
    assign out_req = out_valid;
    assign irq     = (in_ie_q && in_req) || (out_ie_q && out_req);

endmodule

// File: rtl/fir_coproc_chk.sv
module fir_coproc_chk #(
    parameter int FIFO_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           wr_sample,
    input logic                           rd_result,
    input logic                           fifo_full,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    input logic                           drop_q,
    input logic                           out_valid,
    input logic                           eng_fin,
    input logic [23:0]                    result_q,
    input logic                           en_q,
    input logic                           in_req
);
    // R2
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

    // R2
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wr_sample && fifo_full |=> drop_q);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !eng_fin |=> $stable(result_q));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_result && out_valid && !eng_fin |=> !out_valid);

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q && !wr_sample |=> $stable(fifo_level));

    // R10
    in_req_room_chk: assert property (@(posedge clk) disable iff (rst)
        in_req |-> !fifo_full);
endmodule

bind fir_coproc fir_coproc_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_sample  (wr_sample),
    .rd_result  (rd_result),
    .fifo_full  (fifo_full),
    .fifo_level (fifo_level),
    .drop_q     (drop_q),
    .out_valid  (out_valid),
    .eng_fin    (eng_fin),
    .result_q   (result_q),
    .en_q       (en_q),
    .in_req     (in_req)
);

// File: tb/tb_fir_coproc.sv
module tb_fir_coproc;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [23:0] bus_wdata, bus_rdata;
    logic        in_req, out_req, irq;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    fir_coproc dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_req(in_req), .out_req(out_req), .irq(irq)
    );

    localparam logic [23:0] SAMPS [8] = '{
        24'h100000, 24'h7FFFFF, 24'h800000, 24'hFFFFFF,
        24'h000001, 24'h3ABCDE, 24'hC54321, 24'h000000
    };
    localparam logic [23:0] COEFS [4] = '{
        24'h400000, 24'h200000, 24'hF00000, 24'h7FFFFF
    };

    longint hist [64];
    int     nh;
    longint cf [16];

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [23:0] model_out(input int taps);
        longint s = 0;
        longint r;
        for (int j = 0; j < taps; j++)
            if (nh - 1 - j >= 0) s += cf[j] * hist[nh - 1 - j];
        r = (s + 64'sd4194304) >>> 23;
        if (r > 64'sd8388607) r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return r[23:0];
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [23:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #4 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        logic [23:0] st;
        bit got = 0;
        for (int k = 0; k < 200; k++) begin
            bus_read(3'd6, st);
            if (st[2]) begin got = 1; break; end
        end
        check(req, "result valid seen", longint'(got), 1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nh = 0;
        for (int i = 0; i < 16; i++) cf[i] = 0;
    endtask

    task automatic push_and_check(input string req, input logic [23:0] s, input int taps);
        logic [23:0] r;
        bus_write(3'd0, s);
        hist[nh] = sx(s); nh++;
        wait_valid(req);
        bus_read(3'd1, r);
        check(req, "filter output", r, model_out(taps));
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] rv;
        do_reset();

        // R1 reset state
        bus_read(3'd6, rv); check("R1", "csr", rv, 24'h000002);
        bus_read(3'd1, rv); check("R1", "result", rv, 0);
        check("R1", "req lines", {in_req, out_req, irq}, 0);

        // R3 tap count clamp
        bus_write(3'd3, 24'd0);   bus_read(3'd3, rv); check("R3", "taps 0", rv, 1);
        bus_write(3'd3, 24'd100); bus_read(3'd3, rv); check("R3", "taps 100", rv, 16);

        // R5 R4 table walk: 4 taps, history base 3, coefficient base 14 (wraps)
        bus_write(3'd3, 24'd4);
        bus_write(3'd4, 24'd3);
        bus_write(3'd5, 24'd14);
        for (int i = 0; i < 4; i++) begin
            bus_write(3'd2, COEFS[i]);
            cf[i] = sx(COEFS[i]);
        end
        bus_write(3'd6, 24'h000001);
        for (int i = 0; i < 8; i++)
            push_and_check("R5", SAMPS[i], 4);

        // R7 saturation both directions
        do_reset();
        bus_write(3'd3, 24'd2);
        bus_write(3'd2, 24'h7FFFFF); cf[0] = sx(24'h7FFFFF);
        bus_write(3'd2, 24'h7FFFFF); cf[1] = sx(24'h7FFFFF);
        bus_write(3'd6, 24'h000001);
        push_and_check("R7", 24'h7FFFFF, 2);
        push_and_check("R7", 24'h7FFFFF, 2);
        check("R7", "positive clamp", model_out(2), 24'h7FFFFF);
        push_and_check("R7", 24'h800000, 2);
        push_and_check("R7", 24'h800000, 2);
        check("R7", "negative clamp", model_out(2), 24'h800000);

        // R6 rounding of exact halves, with tap count 0 acting as 1 (R3)
        do_reset();
        bus_write(3'd3, 24'd0);
        bus_write(3'd2, 24'h400000); cf[0] = sx(24'h400000);
        bus_write(3'd6, 24'h000001);
        bus_write(3'd0, 24'h000001);
        wait_valid("R6"); bus_read(3'd1, rv); check("R6", "+half rounds up", rv, 24'h000001);
        bus_write(3'd0, 24'hFFFFFF);
        wait_valid("R6"); bus_read(3'd1, rv); check("R6", "-half rounds up", rv, 24'h000000);
        bus_write(3'd0, 24'h000003);
        wait_valid("R6"); bus_read(3'd1, rv); check("R6", "1.5 rounds up", rv, 24'h000002);

        // R2 R9 overflow with engine off
        do_reset();
        bus_write(3'd3, 24'd1);
        bus_write(3'd2, 24'h400000);
        for (int i = 0; i < 5; i++) bus_write(3'd0, 24'h000010 * (i + 1));
        repeat (10) @(negedge clk);
        bus_read(3'd6, rv); check("R2", "full + drop flag, nothing consumed (R9)", rv, 24'h000008);
        check("R10", "in_req off when disabled", in_req, 0);
        bus_write(3'd6, 24'h000029);
        wait_valid("R8");
        bus_read(3'd6, rv); check("R8", "csr while result waits", rv, 24'h000027);
        check("R10", "irq from out_req", {out_req, irq}, 2'b11);
        bus_read(3'd1, rv); check("R8", "first result held", rv, 24'h000008);
        bus_read(3'd6, rv); check("R8", "valid cleared by read", rv[2], 0);
        for (int i = 1; i < 4; i++) begin
            wait_valid("R2");
            bus_read(3'd1, rv); check("R2", "queued sample result", rv, 24'h000008 * (i + 1));
        end
        repeat (30) @(negedge clk);
        bus_read(3'd6, rv); check("R2", "dropped sample produced nothing", rv, 24'h000023);
        check("R10", "in_req on, irq off", {in_req, irq}, 2'b10);
        bus_write(3'd6, 24'h000011);
        @(negedge clk);
        check("R10", "irq from in_req", irq, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule